// File: doc/BRIEF.md
# Paged Receive Ring Buffer Writer

This block takes accepted receive frames from a byte stream and lays them into a circular buffer in a byte-addressed local RAM. The buffer is made of 256-byte pages. It spans from a programmable first page up to, but not including, a programmable end page. Every stored frame begins on a page boundary. A 4-byte header sits at the frame's base page and the frame data follows it. When the frame is complete, the current-page pointer moves to the first page after the frame.

Frames are checked once, at their first byte. A frame is discarded whole if the block is not running, or if the space free up to the host's boundary page is less than one maximum frame plus its header. A discarded frame makes no RAM write and changes no status. Frames shorter than the minimum length are zero-filled up to that length. While the block pads or writes the header, it holds off the stream. The host clears the frame-done flag and can load the current pointer.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, cur_pg is 0, rx_stat is 0, rx_done_flag is 0, ram_we is 0 and in_ready is 1.
- R2: Byte i of an accepted frame is written once, in stream order, at RAM byte address cur_pg*256 + 4 + i, where cur_pg is the value at the frame's first byte.
- R3: A data write address that reaches ring_end_pg*256 continues at ring_first_pg*256. No write ever lands outside the ring.
- R4: A frame shorter than 60 bytes is stored as 60 bytes, with zero bytes after its last real byte.
- R5: The header occupies base page offsets 0 to 3. Offset 0 holds the status byte, offset 1 the next page, offset 2 the stored length plus 4 (low byte) and offset 3 the same value's high byte.
- R6: The next page is the base page plus ceil((stored length + 4)/256). When that reaches ring_end_pg, (ring_end_pg - ring_first_pg) is subtracted. After the header, cur_pg takes this value, and it changes at no other time except through R12.
- R7: The status byte has bit 0 set. It also has bit 5 set exactly when bit 0 of the frame's first byte is 1. On completion the same value appears on rx_stat.
- R8: rx_done_flag is set when a frame's header is complete. It is cleared by rx_done_ack, and a completion in the same cycle wins over the clear.
- R9: While run is 0, a frame is consumed with no RAM write and no change to cur_pg, rx_stat or rx_done_flag.
- R10: Let P be the free page count. P is host_bnd_pg - cur_pg when cur_pg < host_bnd_pg, and otherwise (ring_end_pg - ring_first_pg) - (cur_pg - host_bnd_pg). If P*256 < 1518 at the first byte, the frame is dropped as in R9.
- R11: in_ready is 0 while padding and while writing the header, and 1 otherwise.
- R12: A cur_load pulse loads cur_load_pg into cur_pg, unless a frame completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Block accepts frames when 1 |
| ring_first_pg | input | 8 | First page of the ring |
| ring_end_pg | input | 8 | Page after the last ring page |
| host_bnd_pg | input | 8 | Host boundary page |
| cur_load | input | 1 | Load strobe for the current page |
| cur_load_pg | input | 8 | Value loaded into the current page |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes the stream byte this cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| cur_pg | output | 8 | Current page pointer |
| rx_stat | output | 8 | Status byte of the last stored frame |
| rx_done_flag | output | 1 | Frame-done status bit |
| rx_done_ack | input | 1 | Clears rx_done_flag |

## Verification
Errors in the internal state show up at the ports soon after they occur. A wrong write-address counter puts bytes at the wrong RAM addresses from the next write onward. It shows at the ring end as a write past the end page, or as a gap at the first page. A wrong length count or a wrong state shows within one frame as a bad byte count, missing zero fill or an in_ready that goes high too early. Next-page and free-space errors surface only later, as a wrong cur_pg after the header or as a frame that is dropped or stored against the threshold. The sweeps therefore walk frame lengths across the pad and page-size edges, and place the boundary one page on each side of the threshold.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAD,
    ST_HDR,
    ST_DROP
  } rxr_state_e;

  localparam int STAT_OK_BIT  = 0;
  localparam int STAT_GRP_BIT = 5;
  localparam int HDR_BYTES    = 4;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int PG_W      = 8,
  parameter int PG_SHIFT  = 8,
  parameter int MAX_FRAME = 1514,
  parameter int HDR_B     = 4
) (
  input  logic [PG_W-1:0] cur,
  input  logic [PG_W-1:0] bnd,
  input  logic [PG_W-1:0] first_pg,
  input  logic [PG_W-1:0] end_pg,
  output logic            full
);
  localparam int FW = PG_W + PG_SHIFT + 1;

  function automatic logic [PG_W:0] free_pages(
    input logic [PG_W-1:0] c, input logic [PG_W-1:0] b,
    input logic [PG_W-1:0] s, input logic [PG_W-1:0] e);
    logic [PG_W:0] fp;
    if (c < b) fp = (PG_W+1)'(b) - (PG_W+1)'(c);
    else       fp = ((PG_W+1)'(e) - (PG_W+1)'(s)) - ((PG_W+1)'(c) - (PG_W+1)'(b));
    return fp;
  endfunction

  logic [FW-1:0] free_bytes;
  assign free_bytes = {free_pages(cur, bnd, first_pg, end_pg), {PG_SHIFT{1'b0}}};
  assign full = free_bytes < FW'(MAX_FRAME + HDR_B);
endmodule

// File: rtl/rxr_next_pg.sv
module rxr_next_pg #(
  parameter int PG_W     = 8,
  parameter int PG_SHIFT = 8,
  parameter int LEN_W    = 16
) (
  input  logic [PG_W-1:0]  base,
  input  logic [LEN_W-1:0] total,
  input  logic [PG_W-1:0]  first_pg,
  input  logic [PG_W-1:0]  end_pg,
  output logic [PG_W-1:0]  nxt
);
  localparam int SW = LEN_W + 1;

  function automatic logic [SW-1:0] advance(
    input logic [PG_W-1:0] b, input logic [LEN_W-1:0] t,
    input logic [PG_W-1:0] s, input logic [PG_W-1:0] e);
    logic [SW-1:0] pages;
    logic [SW-1:0] sum;
    pages = (SW'(t) + SW'((1 << PG_SHIFT) - 1)) >> PG_SHIFT;
    sum   = SW'(b) + pages;
    if (sum >= SW'(e)) sum = sum - SW'(e - s);
    return sum;
  endfunction

  logic [SW-1:0] adv;
  assign adv = advance(base, total, first_pg, end_pg);
  assign nxt = adv[PG_W-1:0];
endmodule

// File: rtl/rxr_addr_ctr.sv
module rxr_addr_ctr #(
  parameter int PG_W     = 8,
  parameter int PG_SHIFT = 8,
  parameter int HDR_B    = 4,
  localparam int ADDR_W  = PG_W + PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first,
  input  logic [PG_W-1:0]   base_pg,
  input  logic              step,
  input  logic [PG_W-1:0]   first_pg,
  input  logic [PG_W-1:0]   end_pg,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] wrap_inc(
    input logic [ADDR_W-1:0] a, input logic [PG_W-1:0] s, input logic [PG_W-1:0] e);
    logic [ADDR_W-1:0] n;
    n = a + 1'b1;
    if (n == {e, {PG_SHIFT{1'b0}}}) n = {s, {PG_SHIFT{1'b0}}};
    return n;
  endfunction

  logic [ADDR_W-1:0] ctr;

  assign addr = first ? ({base_pg, {PG_SHIFT{1'b0}}} | ADDR_W'(HDR_B)) : ctr;

  always_ff @(posedge clk) begin
    if (!rst_n)    ctr <= '0;
    else if (step) ctr <= wrap_inc(addr, first_pg, end_pg);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PG_W      = 8,
  parameter int PG_SHIFT  = 8,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  localparam int ADDR_W   = PG_W + PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PG_W-1:0]   ring_first_pg,
  input  logic [PG_W-1:0]   ring_end_pg,
  input  logic [PG_W-1:0]   host_bnd_pg,
  input  logic              cur_load,
  input  logic [PG_W-1:0]   cur_load_pg,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [PG_W-1:0]   cur_pg,
  output logic [7:0]        rx_stat,
  output logic              rx_done_flag,
  input  logic              rx_done_ack
);
  rxr_state_e        state, state_n;
  logic [LEN_W-1:0]  len, len_next, total;
  logic              grp;
  logic [PG_W-1:0]   base_pg, nxt_pg;
  logic [1:0]        hdr_idx;
  logic              ring_full;
  logic [ADDR_W-1:0] data_addr;
  logic [7:0]        stat_byte, hdr_byte;

  // named internal events
  logic accept, sof_go, take_first, drop_go, data_wr;
  logic pad_phase, hdr_phase, drop_phase, store, done_evt;

  assign in_ready   = (state == ST_IDLE) || (state == ST_DATA) || (state == ST_DROP);
  assign accept     = in_valid && in_ready;
  assign sof_go     = (state == ST_IDLE) && accept && in_sof;
  assign take_first = sof_go && run && !ring_full;
  assign drop_go    = sof_go && !(run && !ring_full);
  assign data_wr    = take_first || ((state == ST_DATA) && accept);
  assign pad_phase  = (state == ST_PAD);
  assign hdr_phase  = (state == ST_HDR);
  assign drop_phase = (state == ST_DROP);
  assign store      = data_wr || pad_phase;
  assign done_evt   = hdr_phase && (hdr_idx == 2'd3);
  assign len_next   = (state == ST_IDLE) ? LEN_W'(1) : len + 1'b1;
  assign total      = len + LEN_W'(HDR_BYTES);

  rxr_space #(.PG_W(PG_W), .PG_SHIFT(PG_SHIFT), .MAX_FRAME(MAX_FRAME), .HDR_B(HDR_BYTES)) u_space (
    .cur(cur_pg), .bnd(host_bnd_pg), .first_pg(ring_first_pg), .end_pg(ring_end_pg), .full(ring_full));

  rxr_next_pg #(.PG_W(PG_W), .PG_SHIFT(PG_SHIFT), .LEN_W(LEN_W)) u_next (
    .base(base_pg), .total(total), .first_pg(ring_first_pg), .end_pg(ring_end_pg), .nxt(nxt_pg));

  rxr_addr_ctr #(.PG_W(PG_W), .PG_SHIFT(PG_SHIFT), .HDR_B(HDR_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .first(take_first), .base_pg(cur_pg), .step(store),
    .first_pg(ring_first_pg), .end_pg(ring_end_pg), .addr(data_addr));

  assign stat_byte = 8'(1 << STAT_OK_BIT) | (grp ? 8'(1 << STAT_GRP_BIT) : 8'h00);

  always_comb begin
    unique case (hdr_idx)
      2'd0:    hdr_byte = stat_byte;
      2'd1:    hdr_byte = 8'(nxt_pg);
      2'd2:    hdr_byte = total[7:0];
      default: hdr_byte = 8'(total >> 8);
    endcase
  end

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: begin
        if (take_first)
          state_n = in_eof ? ((len_next < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_HDR) : ST_DATA;
        else if (drop_go && !in_eof)
          state_n = ST_DROP;
      end
      ST_DATA: if (accept && in_eof)
                 state_n = (len_next < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_HDR;
      ST_PAD:  if (len_next >= LEN_W'(MIN_FRAME)) state_n = ST_HDR;
      ST_HDR:  if (hdr_idx == 2'd3) state_n = ST_IDLE;
      ST_DROP: if (accept && in_eof) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      len          <= '0;
      grp          <= 1'b0;
      base_pg      <= '0;
      hdr_idx      <= '0;
      cur_pg       <= '0;
      rx_stat      <= '0;
      rx_done_flag <= 1'b0;
      ram_we       <= 1'b0;
      ram_addr     <= '0;
      ram_wdata    <= '0;
    end else begin
      state <= state_n;
      if (store) len <= len_next;
      if (take_first) begin
        grp     <= in_byte[0];
        base_pg <= cur_pg;
      end
      hdr_idx <= hdr_phase ? hdr_idx + 1'b1 : 2'd0;

      ram_we <= store || hdr_phase;
      if (hdr_phase) begin
        ram_addr  <= {base_pg, {PG_SHIFT{1'b0}}} | ADDR_W'(hdr_idx);
        ram_wdata <= hdr_byte;
      end else if (store) begin
        ram_addr  <= data_addr;
        ram_wdata <= data_wr ? in_byte : 8'h00;
      end

      if (done_evt)      cur_pg <= nxt_pg;
      else if (cur_load) cur_pg <= cur_load_pg;
      if (done_evt) rx_stat <= stat_byte;
      if (done_evt)         rx_done_flag <= 1'b1;
      else if (rx_done_ack) rx_done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PG_W     = 8,
  parameter int PG_SHIFT = 8,
  localparam int ADDR_W  = PG_W + PG_SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PG_W-1:0]   ring_first_pg,
  input logic [PG_W-1:0]   ring_end_pg,
  input logic              cur_load,
  input logic              in_ready,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [7:0]        ram_wdata,
  input logic [PG_W-1:0]   cur_pg,
  input logic [7:0]        rx_stat,
  input logic              rx_done_flag,
  input logic              pad_phase,
  input logic              hdr_phase,
  input logic              drop_phase,
  input logic              done_evt
);
  // R3
  ram_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr >= {ring_first_pg, {PG_SHIFT{1'b0}}}) &&
               (ram_addr <  {ring_end_pg,   {PG_SHIFT{1'b0}}}));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_phase |=> (ram_we && ram_wdata == 8'h00));

  // R11
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_phase || hdr_phase) |-> !in_ready);

  // R8
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> rx_done_flag);

  // R6
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_evt && !cur_load) |=> $stable(cur_pg));

  // R9
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_phase |=> !ram_we);

  // R7
  stat_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> rx_stat[0]);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PG_W(PG_W), .PG_SHIFT(PG_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_first_pg(ring_first_pg), .ring_end_pg(ring_end_pg),
  .cur_load(cur_load), .in_ready(in_ready), .ram_we(ram_we), .ram_addr(ram_addr),
  .ram_wdata(ram_wdata), .cur_pg(cur_pg), .rx_stat(rx_stat), .rx_done_flag(rx_done_flag),
  .pad_phase(pad_phase), .hdr_phase(hdr_phase), .drop_phase(drop_phase), .done_evt(done_evt));

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int CLK_P  = 10;
  localparam int FIRST  = 8'h10;
  localparam int ENDP   = 8'h18;
  localparam int NPG    = ENDP - FIRST;
  localparam int RBYTES = NPG * 256;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b1;
  logic [7:0] ring_first_pg = 8'(FIRST), ring_end_pg = 8'(ENDP), host_bnd_pg = 8'h10;
  logic cur_load = 1'b0; logic [7:0] cur_load_pg = 8'h00;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0; logic [7:0] in_byte = 8'h00;
  logic in_ready, ram_we, rx_done_flag, rx_done_ack = 1'b0;
  logic [15:0] ram_addr; logic [7:0] ram_wdata, cur_pg, rx_stat;

  int n_chk = 0, n_bad = 0, wcnt = 0, oob = 0;
  logic [7:0] mem [0:RBYTES-1];
  int exp_cur;

  rx_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ring_first_pg(ring_first_pg), .ring_end_pg(ring_end_pg),
    .host_bnd_pg(host_bnd_pg), .cur_load(cur_load), .cur_load_pg(cur_load_pg),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte), .in_ready(in_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cur_pg(cur_pg),
    .rx_stat(rx_stat), .rx_done_flag(rx_done_flag), .rx_done_ack(rx_done_ack));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (rst_n && ram_we) begin
    wcnt++;
    if (int'(ram_addr) < FIRST*256 || int'(ram_addr) >= ENDP*256) oob++;
    else mem[int'(ram_addr) - FIRST*256] = ram_wdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed, input logic [7:0] b0);
    return (i == 0) ? b0 : 8'((i * 13 + seed) & 8'hff);
  endfunction

  function automatic int free_b(input int c, input int b);
    return (c == b) ? RBYTES : (((b - c + NPG) % NPG) * 256);
  endfunction

  task automatic send(input int len, input int seed, input logic [7:0] b0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1); in_byte = pat(i, seed, b0);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic frame(input int len, input int seed, input logic [7:0] b0, input string tag);
    bit drop; int w0, plen, tot, nxt, bad, ia;
    drop = !run || (free_b(exp_cur, int'(host_bnd_pg)) < 1518);
    w0 = wcnt;
    send(len, seed, b0);
    chk({tag, " R11 in_ready after last byte"}, int'(in_ready), drop ? 1 : 0);
    repeat (90) @(negedge clk);
    if (drop) begin
      chk({tag, " R9/R10 no writes on drop"}, wcnt - w0, 0);
      chk({tag, " R9/R10 cur_pg kept"}, int'(cur_pg), exp_cur);
      chk({tag, " R9/R10 flag kept"}, int'(rx_done_flag), 0);
      return;
    end
    plen = (len < 60) ? 60 : len;
    tot  = plen + 4;
    nxt  = FIRST + ((exp_cur - FIRST) + (tot + 255) / 256) % NPG;
    chk({tag, " R2 write count"}, wcnt - w0, plen + 4);
    chk({tag, " R3 no write outside ring"}, oob, 0);
    ia = (exp_cur - FIRST) * 256;
    chk({tag, " R5/R7 hdr status"}, int'(mem[ia]), b0[0] ? 8'h21 : 8'h01);
    chk({tag, " R5/R6 hdr next page"}, int'(mem[ia + 1]), nxt);
    chk({tag, " R5 hdr len lo"}, int'(mem[ia + 2]), tot & 255);
    chk({tag, " R5 hdr len hi"}, int'(mem[ia + 3]), tot >> 8);
    bad = 0;
    for (int i = 0; i < plen; i++) begin
      int a; logic [7:0] e;
      a = ((exp_cur - FIRST) * 256 + 4 + i) % RBYTES;
      e = (i < len) ? pat(i, seed, b0) : 8'h00;
      if (mem[a] !== e && bad == 0) begin
        bad = 1;
        $display("FAIL %s R2/R3/R4 byte %0d actual=%0h expected=%0h", tag, i, mem[a], e);
      end
    end
    n_chk++; n_bad += bad;
    chk({tag, " R6 cur_pg"}, int'(cur_pg), nxt);
    chk({tag, " R7 rx_stat"}, int'(rx_stat), b0[0] ? 8'h21 : 8'h01);
    chk({tag, " R8 flag set"}, int'(rx_done_flag), 1);
    @(negedge clk) rx_done_ack = 1'b1;
    @(negedge clk) rx_done_ack = 1'b0;
    chk({tag, " R8 flag cleared"}, int'(rx_done_flag), 0);
    exp_cur = nxt;
  endtask

  initial begin
    for (int i = 0; i < RBYTES; i++) mem[i] = 8'hxx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur_pg", int'(cur_pg), 0);
    chk("R1 rx_stat", int'(rx_stat), 0);
    chk("R1 flag", int'(rx_done_flag), 0);
    chk("R1 ram_we", int'(ram_we), 0);
    chk("R1 in_ready", int'(in_ready), 1);

    cur_load_pg = 8'h10; cur_load = 1'b1;
    @(negedge clk) cur_load = 1'b0;
    chk("R12 cur load", int'(cur_pg), 16'h10);
    exp_cur = 16'h10;

    host_bnd_pg = 8'(exp_cur); frame(1,   3, 8'h01, "f1");
    host_bnd_pg = 8'(exp_cur); frame(59,  5, 8'h00, "f59");
    host_bnd_pg = 8'(exp_cur); frame(60,  7, 8'h02, "f60");
    host_bnd_pg = 8'(exp_cur); frame(61,  9, 8'h03, "f61");
    host_bnd_pg = 8'(exp_cur); frame(252, 1, 8'h04, "f252");
    host_bnd_pg = 8'(exp_cur); frame(253, 2, 8'h05, "f253");
    // cur above boundary, free below threshold then just at/above it
    host_bnd_pg = 8'h10; frame(100, 4, 8'h06, "full_hi_R10");
    host_bnd_pg = 8'h14; frame(100, 4, 8'h06, "full5pg_R10");
    host_bnd_pg = 8'h15; frame(600, 8, 8'h07, "wrap_R3");
    run = 1'b0; host_bnd_pg = 8'(exp_cur); frame(80, 6, 8'h09, "stopped_R9");
    run = 1'b1;
    // cur below boundary by five pages: drop
    host_bnd_pg = 8'(exp_cur + 5); frame(70, 2, 8'h0a, "full_lo_R10");
    host_bnd_pg = 8'(exp_cur); frame(1514, 11, 8'h0b, "max");
    for (int l = 55; l <= 66; l++) begin
      host_bnd_pg = 8'(exp_cur); frame(l, l, 8'(l), "sweep");
    end
    for (int l = 250; l <= 258; l++) begin
      host_bnd_pg = 8'(exp_cur); frame(l, l, 8'(l), "sweep_pg");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule